// File: doc/BRIEF.md
# Parking Bus Arbiter

This block decides which of several masters on one shared synchronous bus may drive it. Each master has its own request input, its own grant output and its own release input. A master raises its request and waits for its grant. It then keeps the bus until it pulses its release. The arbiter chooses the next owner on every cycle, while the current transfer is still running. The new grant therefore appears on the clock edge that samples the release, with no dead cycle in between.

Selection uses a fixed priority in which index 0 is the most important. A served mask keeps low-priority masters from being locked out. A master that has just won is held back while any requester that has not yet been served is waiting. The mask starts again once every waiting requester has had a turn. When the owner releases and nobody else is asking, the grant stays parked with that owner. The owner can then begin another transfer by raising its request again, with no new arbitration.

The controller has three states. ST_IDLE means no grant is held. ST_BUSY means the owner holds the bus. ST_PARKED means the owner has released but still holds the grant.

The transitions are:
- **idle-claim** (ST_IDLE→ST_BUSY): any request is seen.
- **handover** (ST_BUSY→ST_BUSY with a new owner): the owner releases while others are requesting.
- **park** (ST_BUSY→ST_PARKED): the owner releases and nobody else is requesting.
- **resume** (ST_PARKED→ST_BUSY with the same owner): the parked owner requests.
- **steal** (ST_PARKED→ST_BUSY with a new owner): another master requests while the parked owner is silent.
- **reset** (any state→ST_IDLE).

Top module: `bus_arbiter`

## Requirements
- R1: While reset is active, and after reset until the first request, `gnt_o` is all zero.
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: In ST_IDLE, a request sampled at a clock edge produces a grant to one of the requesters, visible right after that edge.
- R4: While a master owns the bus, its grant does not change until it releases. Changes in other masters' requests, and release pulses from masters that do not hold the grant, have no effect.
- R5: When the owner releases while another master is requesting, the new grant appears right after the edge that samples the release.
- R6: Among the eligible requesters, the one with the lowest index wins. Bit i of `req_i`, `rel_i` and `gnt_o` belongs to master i.
- R7: A master that has won is not granted again while some other requester that has not been served since the served mask last cleared is still waiting. The mask clears when no waiting requester remains unserved.
- R8: When the owner releases and no other master is requesting, the grant stays with that owner (ST_PARKED).
- R9: A parked owner that raises its request takes back the bus with no change of grant, even if other masters request in the same cycle.
- R10: While parked, a request from another master, with the owner silent, moves the grant to that master at the next edge.
- R11: Release pulses in ST_IDLE or ST_PARKED change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Per-master bus request, bit i = master i |
| rel_i | input | N | Per-master release pulse, bit i = master i |
| gnt_o | output | N | One-hot (or zero) grant, bit i = master i |

## Verification
The grant is a register, so every result is due on the first rising edge after the stimulus. This covers the idle claim, the handover after a release, the steal from a parked owner and the clear on reset. No result needs more than one cycle. The bench drives requests and releases on the falling edge. It lets exactly one rising edge pass and compares `gnt_o` on the following falling edge. Before each new drive, it confirms that inputs which must be ignored have left the grant unchanged.

// File: rtl/busarb_pkg.sv
`timescale 1ns/1ps
package busarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_PARKED = 2'd2
    } arb_state_t;
endpackage

// File: rtl/busarb_prio_pick.sv
`timescale 1ns/1ps
// Picks the lowest-index set bit of a vector (index 0 has top priority).
module busarb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] vec_i,
    output logic [N-1:0] pick_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign pick_o[i]    = vec_i[i] & ~seen[i];
        assign seen[i + 1]  = seen[i] | vec_i[i];
    end
endmodule

// File: rtl/busarb_fair_mask.sv
`timescale 1ns/1ps
// Served mask: hides masters that already had a turn while unserved
// requesters remain; starts a fresh round when none remain.
module busarb_fair_mask #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_i,
    input  logic         take_i,
    input  logic [N-1:0] win_i,
    output logic [N-1:0] pool_o
);
    logic [N-1:0] served_q;
    logic [N-1:0] elig;
    logic         fresh;

    assign elig   = cand_i & ~served_q;
    assign fresh  = (elig == '0);
    assign pool_o = fresh ? cand_i : elig;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_q <= '0;
        end else if (take_i) begin
            served_q <= (fresh ? '0 : served_q) | win_i;
        end
    end

    // R7: while unserved requesters remain, the chosen winner is never one already served
    a_r7_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !fresh) |-> ((win_i & served_q) == '0));
endmodule

// File: rtl/bus_arbiter.sv
`timescale 1ns/1ps
module bus_arbiter
    import busarb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] rel_i,
    output logic [N-1:0] gnt_o
);
    arb_state_t   state_q, state_d;
    logic [N-1:0] owner_q, owner_d;
    logic [N-1:0] cand;
    logic [N-1:0] pool;
    logic [N-1:0] win;
    logic         take;
    logic         rel_own;
    logic         own_req;

    // Next-owner selection runs every cycle, overlapped with the transfer.
    assign cand    = req_i & ~owner_q;
    assign rel_own = |(rel_i & owner_q);
    assign own_req = |(req_i & owner_q);

    busarb_fair_mask #(.N(N)) u_fair (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand),
        .take_i (take),
        .win_i  (win),
        .pool_o (pool)
    );

    busarb_prio_pick #(.N(N)) u_pick (
        .vec_i  (pool),
        .pick_o (win)
    );

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (|req_i) begin          // idle-claim
                    owner_d = win;
                    take    = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (rel_own) begin
                    if (|cand) begin       // handover
                        owner_d = win;
                        take    = 1'b1;
                    end else begin         // park
                        state_d = ST_PARKED;
                    end
                end
            end
            ST_PARKED: begin
                if (own_req) begin         // resume
                    state_d = ST_BUSY;
                end else if (|cand) begin  // steal
                    owner_d = win;
                    take    = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            default: begin
                state_d = ST_IDLE;
                owner_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Outputs
    always_comb begin
        gnt_o = owner_q;
    end

    // R2: never more than one grant
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R3: an idle request yields a grant to a requester on the next edge
    a_r3_idle_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (|req_i)) |=> ((gnt_o & $past(req_i)) != '0));

    // R4: the owner's grant holds until it releases
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !rel_own) |=> $stable(gnt_o));

    // R5: release with others pending moves the grant at the next edge
    a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && rel_own && (|cand))
        |=> ((gnt_o != $past(gnt_o)) && ((gnt_o & $past(req_i)) != '0)));

    // R8: with nobody else requesting, a held grant stays put
    a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && ((req_i & ~gnt_o) == '0)) |=> $stable(gnt_o));
endmodule

// File: tb/bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_tb_top;
    localparam int N = 4;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] rel_i = '0;
    logic [N-1:0] gnt_o;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_arbiter #(.N(N)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .rel_i (rel_i),
        .gnt_o (gnt_o)
    );

    // Fields: {requirement number, req, rel, expected grant}
    localparam logic [15:0] VEC [0:19] = '{
        {4'd1,  4'b0000, 4'b0000, 4'b0000}, // R1 idle, no request
        {4'd6,  4'b1010, 4'b0000, 4'b0010}, // R6 / R3 claim: 1 beats 3
        {4'd4,  4'b1001, 4'b0001, 4'b0010}, // R4 foreign release ignored
        {4'd5,  4'b1001, 4'b0010, 4'b0001}, // R5 handover to 0
        {4'd5,  4'b1000, 4'b0001, 4'b1000}, // R5 handover to 3
        {4'd7,  4'b0011, 4'b1000, 4'b0001}, // R7 round cleared, 0 wins
        {4'd5,  4'b0011, 4'b0001, 4'b0010}, // R5 to 1
        {4'd7,  4'b0011, 4'b0010, 4'b0001}, // R7 round cleared
        {4'd5,  4'b0101, 4'b0001, 4'b0100}, // R5 to 2
        {4'd7,  4'b1001, 4'b0100, 4'b1000}, // R7 unserved 3 beats served 0
        {4'd7,  4'b0001, 4'b1000, 4'b0001}, // R7 fresh round
        {4'd8,  4'b0000, 4'b0001, 4'b0001}, // R8 park
        {4'd8,  4'b0000, 4'b0000, 4'b0001}, // R8 stays parked
        {4'd11, 4'b0000, 4'b0010, 4'b0001}, // R11 release while parked
        {4'd9,  4'b0011, 4'b0000, 4'b0001}, // R9 owner resumes over 1
        {4'd4,  4'b0010, 4'b0000, 4'b0001}, // R4 holds
        {4'd5,  4'b0010, 4'b0001, 4'b0010}, // R5 to 1
        {4'd8,  4'b0000, 4'b0010, 4'b0010}, // R8 park with 1
        {4'd10, 4'b0100, 4'b0000, 4'b0100}, // R10 steal by 2
        {4'd4,  4'b0000, 4'b0000, 4'b0100}  // R4 holds
    };

    task automatic check(input string tag, input logic [N-1:0] exp);
        n_chk++;
        if (gnt_o !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt_o actual %b expected %b", tag, gnt_o, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] rl,
                        input logic [N-1:0] exp, input string tag);
        req_i = rq;
        rel_i = rl;
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", '0);
        rst_n = 1'b1;

        for (int k = 0; k < 20; k++) begin
            step(VEC[k][11:8], VEC[k][7:4], VEC[k][3:0],
                 $sformatf("R%0d vector %0d", VEC[k][15:12], k));
        end

        // R1: reset while master 2 owns the bus
        rst_n = 1'b0;
        req_i = '0;
        rel_i = '0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset during ownership", '0);
        rst_n = 1'b1;
        step(4'b0000, 4'b0000, 4'b0000, "R1 idle after reset");
        step(4'b0000, 4'b1111, 4'b0000, "R11 release while idle");
        step(4'b1111, 4'b0000, 4'b0001, "R6 all request");
        step(4'b1111, 4'b0001, 4'b0010, "R5 rotation to 1");
        step(4'b1111, 4'b0010, 4'b0100, "R7 rotation to 2");
        step(4'b1111, 4'b0100, 4'b1000, "R7 rotation to 3");
        step(4'b1111, 4'b1000, 4'b0001, "R7 round restarts at 0");
        step(4'b0000, 4'b0000, 4'b0001, "R2 single grant kept");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule